// File: doc/BRIEF.md
# Indirect Packet Buffer Access Port

This block gives an 8-bit host bus access to an on-chip packet buffer of 2048 bytes. The host never addresses the buffer directly. It loads an address pointer through two pointer registers and then moves bytes through one data register. A holding register stands between the data register and the RAM. Reads are fetched into it ahead of time and writes are posted from it later, so no host bus cycle waits on the buffer.

The RAM has one port, and a second internal requester (a network engine) also uses it. A round-robin arbiter shares that port. It allows at most one RAM access per arbitration tick. A control pin sets the tick to every clock or to every other clock.

For sequential transfers the host enables auto-increment. The pointer then advances after every data-register read in read direction, and after every committed write in write direction.

Top module: `bufacc_top`

## Requirements
- R1: Register offsets on `hb_addr` are 2 for pointer-high, 3 for pointer-low and 4 for data. Pointer-high keeps bit 7 (auto-increment enable), bit 6 (direction, 1 = read, 0 = write) and bits [2:0] (pointer bits [10:8]); its other bits read as 0. Reading offset 3 returns pointer bits [7:0] and reading offset 4 returns the holding register.
- R2: Writing offset 3 loads the pointer with {pointer-high[2:0], written byte}. Writing pointer-high alone leaves the pointer unchanged.
- R3: A pointer load in read direction starts a fetch. `hb_ready` is low from the next cycle until the byte at the pointer is in the data register, and a read of offset 4 then returns that byte.
- R4: In read direction with auto-increment, each read of offset 4 advances the pointer by one and fetches the next byte. Without auto-increment the pointer stays put and the data register keeps its value.
- R5: A write of offset 4 in write direction is posted. `hb_ready` is low until the byte is committed to the RAM at the pointer. With auto-increment the pointer then advances by one.
- R6: Pointer advances wrap from 7FFh to 000h in both directions.
- R7: The following are ignored: data-register writes in read direction, offset-3 or offset-4 writes while `hb_ready` is low, and data-register reads in write direction. Ignored means the pointer, the data register and the RAM keep their values.
- R8: The network port is valid/ready. A transfer happens in a cycle where `net_valid` and `net_ready` are both high. The requester holds its command stable until then. For a read, `net_rvalid` is high in the next cycle with the byte on `net_rdata`.
- R9: If the host path and the network port both request on the same tick, the grant goes to the one not granted last. With `net_valid` held high, a host fetch completes within 4 cycles of the pointer load.
- R10: With `slow_arb` high, grants occur only on alternate cycles (a valid held high gets one transfer every two cycles). With `slow_arb` low, a grant can occur every cycle.
- R11: After reset `hb_ready` is 1, and pointer-high, pointer and data register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_arb | input | 1 | 1 = arbitration tick every other clock |
| hb_wr | input | 1 | Host register write strobe |
| hb_rd | input | 1 | Host register read strobe |
| hb_addr | input | 3 | Host register offset |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data (combinational from offset) |
| hb_ready | output | 1 | No fetch or posted write pending |
| net_valid | input | 1 | Network access request |
| net_we | input | 1 | Network access is a write |
| net_addr | input | 11 | Network buffer address |
| net_wdata | input | 8 | Network write data |
| net_ready | output | 1 | Network access accepted this cycle |
| net_rvalid | output | 1 | Network read data valid |
| net_rdata | output | 8 | Network read data |

## Verification
A wrong pointer shows up at the ports quickly. The next data-register read returns a byte that differs from what the bench model stored, or a read of offset 3 returns an unexpected low byte; either appears within one transfer. A stuck pending operation or a lost grant leaves `hb_ready` low past the bounded wait, and the bench reports it within a few cycles. A broken arbitration rate or turn order changes how many cycles `net_ready` is high in a fixed window.

// File: rtl/bufacc_pkg.sv
package bufacc_pkg;
  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] OFF_PHI  = 3'd2;
  localparam logic [REG_AW-1:0] OFF_PLO  = 3'd3;
  localparam logic [REG_AW-1:0] OFF_DATA = 3'd4;
  localparam int unsigned BIT_INC = 7;
  localparam int unsigned BIT_DIR = 6;
  typedef enum logic [1:0] {OP_IDLE, OP_FETCH, OP_POST} op_e;
endpackage

// File: rtl/bufacc_ram.sv
module bufacc_ram #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/bufacc_arbiter.sv
module bufacc_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  input  logic req_host,
  input  logic req_net,
  output logic gnt_host,
  output logic gnt_net
);
  logic phase_q, last_host_q, tick;

  assign tick = !slow || phase_q;

  always_comb begin
    gnt_host = tick && req_host && (!req_net || !last_host_q);
    gnt_net  = tick && req_net  && (!req_host || last_host_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= 1'b0;
      last_host_q <= 1'b0;
    end else begin
      phase_q <= slow ? !phase_q : 1'b0;
      if (gnt_host)     last_host_q <= 1'b1;
      else if (gnt_net) last_host_q <= 1'b0;
    end
  end

  p_gnt_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_host, gnt_net}));
  p_gnt_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_host |-> req_host) and (gnt_net |-> req_net));
  p_slow_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slow && (gnt_host || gnt_net)) |=> (!slow || !(gnt_host || gnt_net)));
endmodule

// File: rtl/bufacc_hostif.sv
module bufacc_hostif
  import bufacc_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_wr,
  input  logic              hb_rd,
  input  logic [REG_AW-1:0] hb_addr,
  input  logic [DW-1:0]     hb_wdata,
  output logic [DW-1:0]     hb_rdata,
  output logic              hb_ready,
  output logic              req,
  input  logic              gnt,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata
);
  localparam int unsigned HI_AW = AW - DW;
  localparam logic [DW-1:0] HI_MASK = DW'(8'hC0) | DW'((1 << HI_AW) - 1);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [DW-1:0] hi_q, hold_q;
  logic [AW-1:0] ptr_q;
  op_e           op_q;
  logic          infl_q;
  logic          wr_hi, wr_lo, wr_data, rd_data;

  assign wr_hi    = hb_wr && (hb_addr == OFF_PHI);
  assign wr_lo    = hb_wr && (hb_addr == OFF_PLO);
  assign wr_data  = hb_wr && (hb_addr == OFF_DATA);
  assign rd_data  = hb_rd && (hb_addr == OFF_DATA);
  assign hb_ready = (op_q == OP_IDLE);
  assign req      = (op_q != OP_IDLE) && !infl_q;
  assign ram_we   = (op_q == OP_POST);
  assign ram_addr = ptr_q;
  assign ram_wdata = hold_q;

  always_comb begin
    unique case (hb_addr)
      OFF_PHI:  hb_rdata = hi_q;
      OFF_PLO:  hb_rdata = ptr_q[DW-1:0];
      OFF_DATA: hb_rdata = hold_q;
      default:  hb_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      hold_q <= '0;
      ptr_q  <= '0;
      op_q   <= OP_IDLE;
      infl_q <= 1'b0;
    end else begin
      if (wr_hi) hi_q <= hb_wdata & HI_MASK;
      if (hb_ready) begin
        if (wr_lo) begin
          ptr_q <= {hi_q[HI_AW-1:0], hb_wdata};
          if (hi_q[BIT_DIR]) op_q <= OP_FETCH;
        end else if (wr_data && !hi_q[BIT_DIR]) begin
          hold_q <= hb_wdata;
          op_q   <= OP_POST;
        end else if (rd_data && hi_q[BIT_DIR] && hi_q[BIT_INC]) begin
          ptr_q <= ptr_q + ONE;
          op_q  <= OP_FETCH;
        end
      end
      if (gnt && op_q == OP_POST) begin
        op_q <= OP_IDLE;
        if (hi_q[BIT_INC]) ptr_q <= ptr_q + ONE;
      end
      if (gnt && op_q == OP_FETCH) infl_q <= 1'b1;
      if (infl_q) begin
        hold_q <= ram_rdata;
        infl_q <= 1'b0;
        op_q   <= OP_IDLE;
      end
    end
  end

  p_load_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && hb_ready && hi_q[BIT_DIR]) |=> !hb_ready);
  p_idle_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hb_ready |-> !req);
  p_post_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && hb_ready && !hi_q[BIT_DIR]) |=> (ram_we && !hb_ready));
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hb_ready && !infl_q && !gnt) |=> ($stable(ptr_q) && $stable(hold_q)));
endmodule

// File: rtl/bufacc_top.sv
module bufacc_top
  import bufacc_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_arb,
  input  logic              hb_wr,
  input  logic              hb_rd,
  input  logic [REG_AW-1:0] hb_addr,
  input  logic [DATA_W-1:0] hb_wdata,
  output logic [DATA_W-1:0] hb_rdata,
  output logic              hb_ready,
  input  logic              net_valid,
  input  logic              net_we,
  input  logic [ADDR_W-1:0] net_addr,
  input  logic [DATA_W-1:0] net_wdata,
  output logic              net_ready,
  output logic              net_rvalid,
  output logic [DATA_W-1:0] net_rdata
);
  logic              h_req, h_gnt, n_gnt, h_we;
  logic [ADDR_W-1:0] h_addr, m_addr;
  logic [DATA_W-1:0] h_wdata, m_wdata, m_rdata;
  logic              m_en, m_we, rvalid_q;

  bufacc_hostif #(.AW(ADDR_W), .DW(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_ready(hb_ready),
    .req(h_req), .gnt(h_gnt), .ram_we(h_we), .ram_addr(h_addr),
    .ram_wdata(h_wdata), .ram_rdata(m_rdata));

  bufacc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .slow(slow_arb), .req_host(h_req),
    .req_net(net_valid), .gnt_host(h_gnt), .gnt_net(n_gnt));

  assign m_en    = h_gnt || n_gnt;
  assign m_we    = h_gnt ? h_we    : net_we;
  assign m_addr  = h_gnt ? h_addr  : net_addr;
  assign m_wdata = h_gnt ? h_wdata : net_wdata;

  bufacc_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(clk), .en(m_en), .we(m_we), .addr(m_addr), .wdata(m_wdata),
    .rdata(m_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= n_gnt && !net_we;
  end

  assign net_ready  = n_gnt;
  assign net_rvalid = rvalid_q;
  assign net_rdata  = m_rdata;

  p_net_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (net_valid && net_ready && !net_we) |=> net_rvalid);
  p_rvalid_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    net_rvalid |-> $past(net_ready));
endmodule

// File: tb/tb_bufacc_top.sv
`timescale 1ns/1ps
module tb_bufacc_top;
  logic clk = 1'b0, rst_n = 1'b0, slow_arb = 1'b0;
  logic hb_wr = 1'b0, hb_rd = 1'b0;
  logic [2:0] hb_addr = '0;
  logic [7:0] hb_wdata = '0, hb_rdata;
  logic hb_ready;
  logic net_valid = 1'b0, net_we = 1'b0;
  logic [10:0] net_addr = '0;
  logic [7:0] net_wdata = '0, net_rdata;
  logic net_ready, net_rvalid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [2048];

  always #2 clk = ~clk;

  bufacc_top dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); hb_addr = a; hb_wdata = d; hb_wr = 1'b1;
    @(negedge clk); hb_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); hb_addr = a; hb_rd = 1'b1; #1 d = hb_rdata;
    @(negedge clk); hb_rd = 1'b0;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!hb_ready && n < 40) begin @(negedge clk); n++; end
  endtask

  function automatic logic [7:0] hi_byte(input bit inc, input bit rd, input logic [10:0] a);
    return {inc, rd, 3'b000, a[10:8]};
  endfunction

  task automatic load_ptr(input bit inc, input bit rd, input logic [10:0] a);
    hwr(3'd2, hi_byte(inc, rd, a));
    hwr(3'd3, a[7:0]);
  endtask

  task automatic net_xfer(input bit we, input logic [10:0] a, input logic [7:0] d,
                          output logic [7:0] q, output bit rv);
    @(negedge clk); net_valid = 1'b1; net_we = we; net_addr = a; net_wdata = d;
    forever begin #1; if (net_ready) break; @(negedge clk); end
    @(negedge clk); rv = net_rvalid; q = net_rdata; net_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic [10:0] base;
    int n, cnt;
    bit rv, prev, consec, lowseen;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(hb_ready === 1'b1, "R11 ready", hb_ready, 1);
    hrd(3'd2, d); chk(d === 8'h00, "R11 ptr-high", d, 0);
    hrd(3'd3, d); chk(d === 8'h00, "R11 ptr-low", d, 0);
    hrd(3'd4, d); chk(d === 8'h00, "R11 data", d, 0);

    // R5 posted auto-increment writes
    base = 11'($urandom);
    load_ptr(1'b1, 1'b0, base);
    for (int i = 0; i < 8; i++) begin
      d = 8'($urandom);
      hwr(3'd4, d);
      chk(hb_ready === 1'b0, "R5 busy after write", hb_ready, 0);
      wait_rdy(n);
      chk(n <= 3, "R5 commit time", n, 3);
      model[11'(base + 11'(i))] = d;
    end
    hrd(3'd3, d); chk(d === 8'(base + 11'd8), "R5 ptr advanced", d, 8'(base + 11'd8));

    // R1/R2/R3/R4 read back
    load_ptr(1'b1, 1'b1, base);
    chk(hb_ready === 1'b0, "R3 fetch pending", hb_ready, 0);
    wait_rdy(n);
    hrd(3'd2, d); chk(d === hi_byte(1'b1, 1'b1, base), "R1 ptr-high read", d, hi_byte(1'b1, 1'b1, base));
    hwr(3'd2, hi_byte(1'b1, 1'b1, ~base));
    hrd(3'd3, d); chk(d === base[7:0], "R2 high write keeps pointer", d, base[7:0]);
    hwr(3'd2, hi_byte(1'b1, 1'b1, base));
    for (int i = 0; i < 8; i++) begin
      hrd(3'd4, d);
      chk(d === model[11'(base + 11'(i))], "R4 sequential read", d, model[11'(base + 11'(i))]);
      wait_rdy(n);
    end

    // R6 wrap in write and read
    load_ptr(1'b1, 1'b0, 11'h7FF);
    hwr(3'd4, 8'hA5); wait_rdy(n); model[11'h7FF] = 8'hA5;
    hwr(3'd4, 8'h5A); wait_rdy(n); model[11'h000] = 8'h5A;
    hrd(3'd3, d); chk(d === 8'h01, "R6 write wrap pointer", d, 1);
    hrd(3'd2, d); chk(d === 8'h87, "R1 high bits kept", d, 8'h87);
    load_ptr(1'b1, 1'b1, 11'h7FF); wait_rdy(n);
    hrd(3'd4, d); chk(d === 8'hA5, "R6 read at 7FF", d, 8'hA5); wait_rdy(n);
    hrd(3'd4, d); chk(d === 8'h5A, "R6 read wraps to 000", d, 8'h5A); wait_rdy(n);
    hrd(3'd3, d); chk(d === 8'h01, "R6 read wrap pointer", d, 1);

    // R4 no auto-increment
    load_ptr(1'b0, 1'b1, base); wait_rdy(n);
    hrd(3'd4, d); chk(d === model[base], "R4 no-inc read", d, model[base]);
    chk(hb_ready === 1'b1, "R4 no fetch without inc", hb_ready, 1);
    hrd(3'd4, d); chk(d === model[base], "R4 no-inc repeat", d, model[base]);
    hrd(3'd3, d); chk(d === base[7:0], "R4 pointer held", d, base[7:0]);

    // R7 ignored accesses
    hwr(3'd4, ~model[base]);
    chk(hb_ready === 1'b1, "R7 read-dir write not posted", hb_ready, 1);
    hrd(3'd4, d); chk(d === model[base], "R7 data reg kept", d, model[base]);
    load_ptr(1'b0, 1'b1, base); wait_rdy(n);
    hrd(3'd4, d); chk(d === model[base], "R7 RAM kept", d, model[base]);
    load_ptr(1'b1, 1'b0, base);
    hrd(3'd4, d);
    hrd(3'd3, d); chk(d === base[7:0], "R7 write-dir read no advance", d, base[7:0]);
    d2 = 8'($urandom);
    @(negedge clk); hb_addr = 3'd4; hb_wdata = d2; hb_wr = 1'b1;
    @(negedge clk); hb_wr = 1'b0; hb_wdata = ~d2;
    hb_wr = 1'b1; @(negedge clk); hb_wr = 1'b0;
    wait_rdy(n);
    model[base] = d2;
    load_ptr(1'b1, 1'b1, base); wait_rdy(n);
    hrd(3'd4, d); chk(d === d2, "R7 first write kept", d, d2); wait_rdy(n);
    hrd(3'd4, d); chk(d === model[11'(base + 11'd1)], "R7 busy write dropped", d, model[11'(base + 11'd1)]);
    wait_rdy(n);

    // R8 network port
    net_xfer(1'b1, 11'h123, 8'h3C, d, rv); model[11'h123] = 8'h3C;
    net_xfer(1'b0, 11'h123, 8'h00, d, rv);
    chk(rv === 1'b1, "R8 rvalid", rv, 1);
    chk(d === 8'h3C, "R8 net read", d, 8'h3C);
    net_xfer(1'b0, base, 8'h00, d, rv);
    chk(d === model[base], "R8 net sees host data", d, model[base]);
    load_ptr(1'b0, 1'b1, 11'h123); wait_rdy(n);
    hrd(3'd4, d); chk(d === 8'h3C, "R8 host sees net data", d, 8'h3C);

    // R9 contention
    @(negedge clk); net_valid = 1'b1; net_we = 1'b0; net_addr = 11'h010;
    load_ptr(1'b0, 1'b1, base);
    n = 0; lowseen = 1'b0;
    while (!hb_ready && n < 40) begin
      #1 if (!net_ready) lowseen = 1'b1;
      @(negedge clk); n++;
    end
    chk(n <= 4, "R9 host fetch bound", n, 4);
    chk(lowseen, "R9 net yields turn", lowseen, 1);
    hrd(3'd4, d); chk(d === model[base], "R9 host data under load", d, model[base]);

    // R10 arbitration rate
    @(negedge clk); slow_arb = 1'b1; @(negedge clk);
    cnt = 0; prev = 1'b0; consec = 1'b0;
    for (int i = 0; i < 10; i++) begin
      #1 if (net_ready) begin cnt++; if (prev) consec = 1'b1; end
      prev = net_ready;
      @(negedge clk);
    end
    chk(cnt == 5, "R10 slow grant count", cnt, 5);
    chk(!consec, "R10 slow no back-to-back", consec, 0);
    slow_arb = 1'b0; @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      #1 if (net_ready) cnt++;
      @(negedge clk);
    end
    chk(cnt == 10, "R10 full rate count", cnt, 10);
    net_valid = 1'b0;

    // random single-byte round trips
    for (int k = 0; k < 20; k++) begin
      base = 11'($urandom);
      d2 = 8'($urandom);
      load_ptr(1'b0, 1'b0, base);
      hwr(3'd4, d2); wait_rdy(n);
      model[base] = d2;
      slow_arb = k[0];
      load_ptr(1'b0, 1'b1, base); wait_rdy(n);
      hrd(3'd4, d);
      chk(d === d2, "R2 R3 R5 random round trip", d, d2);
    end
    slow_arb = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule